// File: doc/BRIEF.md
# Dual-Processor Shared Memory Strobe Decoder

This block generates the active-low chip selects and read/write strobes for a small memory system shared by two processors. The memories are a boot ROM, a communication RAM that both processors can reach, and four RAM banks private to the secondary processor. A single ownership line decides which processor drives the ROM and communication RAM strobes. The primary processor takes them while it requests the boot ROM. It also takes them while it requests the communication RAM, provided the secondary processor is out of reset and has granted its bus. At all other times the secondary processor owns them, and its upper address bits are decoded into memory regions.

While it owns the memories, the primary processor also has its address and data bus buffers enabled. When the primary processor reads the boot ROM, the ROM's address bit 12 is forced high, so it fetches from the upper 4 KiB of the ROM. When the secondary processor reads it, that bit is driven low, so only the lower 4 KiB are visible to it. That image repeats across its 8 KiB window. The block is purely combinational: every output follows its inputs within the same cycle.

Top module: `dual_cpu_mem_select`

## Requirements
- R1: The primary processor owns the shared memories (`sel_sub`=0, `m_abuf_en_n`=0, `m_dbuf_en_n`=0) when `m_boot_req_n`=0, or when `m_ram_req_n`=0 with `s_reset_n`=1 and `s_grant_n`=0. Otherwise `sel_sub`=1 and both buffer enables are 1.
- R2: With the primary processor as owner, `rom_ce_n` equals `m_boot_req_n`. `rom_oe_n` is 0 only when `m_boot_req_n`=0, `m_rd_n`=0 and `m_wr_n`=1. `rom_a12` is 1.
- R3: With the primary processor as owner through a RAM grant and `m_boot_req_n`=1, `com_cs_n`=0. `com_oe_n` is 0 only for `m_rd_n`=0 with `m_wr_n`=1, and `com_we_n` is 0 only for `m_wr_n`=0 with `m_rd_n`=1. While a boot request is active, `com_cs_n`=1.
- R4: While the primary processor owns the memories, `bank_cs_n` is all ones and `bank_oe_n` and `bank_we_n` are 1, whatever the secondary processor's inputs are.
- R5: With the secondary processor as owner, `s_addr_hi` (address bits 15:11) in 0..3 (address 0000-1FFF) gives `rom_ce_n`=0. `rom_oe_n` is 0 only when also `s_mreq_n`=0, `s_rd_n`=0 and `s_wr_n`=1. `rom_a12` is 0.
- R6: With the secondary processor as owner, `s_addr_hi` in 4..7 (address 2000-3FFF) gives `com_cs_n`=0. `com_oe_n` is 0 for `s_mreq_n`=0 with a read only, and `com_we_n` is 0 for `s_mreq_n`=0 with a write only.
- R7: With the secondary processor as owner, `s_addr_hi` = 8+k for k in 0..3 (address 4000+k*0800) drives `bank_cs_n[k]`=0. `bank_oe_n` and `bank_we_n` are then gated as in R6.
- R8: With the secondary processor as owner, `s_addr_hi` of 12 or more (address 6000-FFFF) leaves every chip select and strobe at 1.
- R9: At most one of `rom_ce_n`, `com_cs_n` and the bits of `bank_cs_n` is 0 at any time.
- R10: A read and a write requested together by the owning processor produce no output or write enable. No device ever sees its output enable and its write enable at 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_boot_req_n | input | 1 | Primary processor boot-ROM request, active low |
| m_ram_req_n | input | 1 | Primary processor communication-RAM request, active low |
| m_rd_n | input | 1 | Primary processor read strobe, active low |
| m_wr_n | input | 1 | Primary processor write strobe, active low |
| s_reset_n | input | 1 | Secondary processor reset line, high when running |
| s_grant_n | input | 1 | Secondary processor bus grant, active low |
| s_addr_hi | input | 5 | Secondary processor address bits 15:11 |
| s_mreq_n | input | 1 | Secondary processor memory request, active low |
| s_rd_n | input | 1 | Secondary processor read strobe, active low |
| s_wr_n | input | 1 | Secondary processor write strobe, active low |
| sel_sub | output | 1 | Ownership line: 1 = secondary processor drives shared strobes |
| m_abuf_en_n | output | 1 | Primary processor address buffer enable, active low |
| m_dbuf_en_n | output | 1 | Primary processor data buffer enable, active low |
| rom_ce_n | output | 1 | Boot ROM chip enable |
| rom_oe_n | output | 1 | Boot ROM output enable |
| rom_a12 | output | 1 | Boot ROM address bit 12 |
| com_cs_n | output | 1 | Communication RAM chip select |
| com_oe_n | output | 1 | Communication RAM output enable |
| com_we_n | output | 1 | Communication RAM write enable |
| bank_cs_n | output | 4 | Private RAM bank chip selects, bit k = bank k |
| bank_oe_n | output | 1 | Private RAM banks output enable (shared) |
| bank_we_n | output | 1 | Private RAM banks write enable (shared) |

## Verification
The checker's properties assume that every input holds a defined 0 or 1 and changes only between evaluations, so that the combinational outputs have settled when they are observed. The bench changes inputs just after a rising edge and samples outputs at the falling edge. It walks every combination of the six primary-side controls, the three secondary strobes and all 32 values of the upper address. This covers read and write requested together, and ownership requests that arrive while the grant is missing.

// File: rtl/msel_pkg.sv
package msel_pkg;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  // {read_ok, write_ok}; both low together is treated as no access
  function automatic logic [1:0] rw_qual(input logic rd_n, input logic wr_n);
    return {(!rd_n && wr_n), (!wr_n && rd_n)};
  endfunction

  function automatic strobe_t gate_strobe(input logic hit, input logic go,
                                          input logic [1:0] rw);
    strobe_t s;
    s.cs_n = !hit;
    s.oe_n = !(hit && go && rw[1]);
    s.we_n = !(hit && go && rw[0]);
    return s;
  endfunction

endpackage

// File: rtl/msel_owner.sv
module msel_owner (
  input  logic m_boot_req_n,
  input  logic m_ram_req_n,
  input  logic s_reset_n,
  input  logic s_grant_n,
  output logic main_own,
  output logic main_rom_hit,
  output logic main_ram_hit
);

  always_comb begin
    main_rom_hit = !m_boot_req_n;
    // boot request has priority over the RAM grant
    main_ram_hit = !m_ram_req_n && s_reset_n && !s_grant_n && m_boot_req_n;
    main_own     = main_rom_hit || main_ram_hit;
  end

endmodule

// File: rtl/msel_sub_decode.sv
module msel_sub_decode
  import msel_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEG_W     = 3,
  parameter int BANK_LOG2 = 11,
  parameter int N_BANKS   = 4,
  parameter int BANK_SEG  = 2
) (
  input  logic                        en,
  input  logic [ADDR_W-1:BANK_LOG2]   addr_hi,
  input  logic                        mreq_n,
  input  logic                        rd_n,
  input  logic                        wr_n,
  output strobe_t                     rom,
  output strobe_t                     com,
  output logic [N_BANKS-1:0]          bank_cs_n,
  output logic                        bank_oe_n,
  output logic                        bank_we_n
);

  localparam int SEG_LSB = ADDR_W - SEG_W;
  localparam int IDX_W   = SEG_LSB - BANK_LOG2;
  localparam logic [SEG_W-1:0] ROM_CODE  = '0;
  localparam logic [SEG_W-1:0] COM_CODE  = SEG_W'(1);
  localparam logic [SEG_W-1:0] BANK_CODE = SEG_W'(BANK_SEG);

  logic [SEG_W-1:0]   seg;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         rw;
  logic               go;
  logic               rom_hit;
  logic               com_hit;
  logic [N_BANKS-1:0] bank_hit;

  always_comb begin
    seg     = addr_hi[ADDR_W-1:SEG_LSB];
    idx     = addr_hi[SEG_LSB-1:BANK_LOG2];
    rw      = rw_qual(rd_n, wr_n);
    go      = !mreq_n;
    rom_hit = en && (seg == ROM_CODE);
    com_hit = en && (seg == COM_CODE);
  end

  for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    always_comb begin
      bank_hit[i]  = en && (seg == BANK_CODE) && (idx == MY_IDX);
      bank_cs_n[i] = !bank_hit[i];
    end
  end

  always_comb begin
    rom       = gate_strobe(rom_hit, go, {rw[1], 1'b0});
    com       = gate_strobe(com_hit, go, rw);
    bank_oe_n = !((|bank_hit) && go && rw[1]);
    bank_we_n = !((|bank_hit) && go && rw[0]);
  end

endmodule

// File: rtl/msel_strobe_mux.sv
module msel_strobe_mux
  import msel_pkg::*;
(
  input  logic    sel_sub,
  input  strobe_t main_rom,
  input  strobe_t main_com,
  input  strobe_t sub_rom,
  input  strobe_t sub_com,
  output strobe_t rom,
  output strobe_t com,
  output logic    rom_a12
);

  always_comb begin
    rom     = sel_sub ? sub_rom : main_rom;
    com     = sel_sub ? sub_com : main_com;
    // primary boot code lives in the upper ROM half; secondary sees the lower half only
    rom_a12 = !sel_sub;
  end

endmodule

// File: rtl/dual_cpu_mem_select.sv
module dual_cpu_mem_select
  import msel_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_LOG2 = 11,
  parameter int N_BANKS   = 4
) (
  input  logic                      m_boot_req_n,
  input  logic                      m_ram_req_n,
  input  logic                      m_rd_n,
  input  logic                      m_wr_n,
  input  logic                      s_reset_n,
  input  logic                      s_grant_n,
  input  logic [ADDR_W-1:BANK_LOG2] s_addr_hi,
  input  logic                      s_mreq_n,
  input  logic                      s_rd_n,
  input  logic                      s_wr_n,
  output logic                      sel_sub,
  output logic                      m_abuf_en_n,
  output logic                      m_dbuf_en_n,
  output logic                      rom_ce_n,
  output logic                      rom_oe_n,
  output logic                      rom_a12,
  output logic                      com_cs_n,
  output logic                      com_oe_n,
  output logic                      com_we_n,
  output logic [N_BANKS-1:0]        bank_cs_n,
  output logic                      bank_oe_n,
  output logic                      bank_we_n
);

  logic    main_own;
  logic    main_rom_hit;
  logic    main_ram_hit;
  logic [1:0] m_rw;
  strobe_t main_rom;
  strobe_t main_com;
  strobe_t sub_rom;
  strobe_t sub_com;
  strobe_t rom_s;
  strobe_t com_s;

  msel_owner u_owner (
    .m_boot_req_n (m_boot_req_n),
    .m_ram_req_n  (m_ram_req_n),
    .s_reset_n    (s_reset_n),
    .s_grant_n    (s_grant_n),
    .main_own     (main_own),
    .main_rom_hit (main_rom_hit),
    .main_ram_hit (main_ram_hit)
  );

  always_comb begin
    sel_sub     = !main_own;
    m_abuf_en_n = !main_own;
    m_dbuf_en_n = !main_own;
    m_rw        = rw_qual(m_rd_n, m_wr_n);
    main_rom    = gate_strobe(main_rom_hit, 1'b1, {m_rw[1], 1'b0});
    main_com    = gate_strobe(main_ram_hit, 1'b1, m_rw);
  end

  msel_sub_decode #(
    .ADDR_W    (ADDR_W),
    .SEG_W     (3),
    .BANK_LOG2 (BANK_LOG2),
    .N_BANKS   (N_BANKS),
    .BANK_SEG  (2)
  ) u_sub (
    .en        (sel_sub),
    .addr_hi   (s_addr_hi),
    .mreq_n    (s_mreq_n),
    .rd_n      (s_rd_n),
    .wr_n      (s_wr_n),
    .rom       (sub_rom),
    .com       (sub_com),
    .bank_cs_n (bank_cs_n),
    .bank_oe_n (bank_oe_n),
    .bank_we_n (bank_we_n)
  );

  msel_strobe_mux u_mux (
    .sel_sub  (sel_sub),
    .main_rom (main_rom),
    .main_com (main_com),
    .sub_rom  (sub_rom),
    .sub_com  (sub_com),
    .rom      (rom_s),
    .com      (com_s),
    .rom_a12  (rom_a12)
  );

  always_comb begin
    rom_ce_n = rom_s.cs_n;
    rom_oe_n = rom_s.oe_n;
    com_cs_n = com_s.cs_n;
    com_oe_n = com_s.oe_n;
    com_we_n = com_s.we_n;
  end

  logic unused_rom_we;
  assign unused_rom_we = rom_s.we_n;

endmodule

// File: rtl/msel_chk.sv
module msel_chk #(
  parameter int ADDR_W    = 16,
  parameter int BANK_LOG2 = 11,
  parameter int N_BANKS   = 4
) (
  input logic                      m_boot_req_n,
  input logic                      m_ram_req_n,
  input logic                      m_rd_n,
  input logic                      m_wr_n,
  input logic                      s_reset_n,
  input logic                      s_grant_n,
  input logic [ADDR_W-1:BANK_LOG2] s_addr_hi,
  input logic                      s_rd_n,
  input logic                      s_wr_n,
  input logic                      sel_sub,
  input logic                      rom_oe_n,
  input logic                      rom_ce_n,
  input logic                      rom_a12,
  input logic                      com_cs_n,
  input logic                      com_oe_n,
  input logic                      com_we_n,
  input logic [N_BANKS-1:0]        bank_cs_n,
  input logic                      bank_oe_n,
  input logic                      bank_we_n
);

  logic [2:0] seg;
  assign seg = s_addr_hi[ADDR_W-1 -: 3];

  always_comb begin
    // R1
    main_owner_chk: assert ((!m_boot_req_n || (!m_ram_req_n && s_reset_n && !s_grant_n)) == !sel_sub)
      else $error("ownership line disagrees with requests");
    // R2
    boot_bank_chk: assert (!(!sel_sub && !rom_oe_n) || rom_a12)
      else $error("primary ROM read without bit 12 high");
    // R4
    sub_quiet_chk: assert (sel_sub || ((&bank_cs_n) && bank_oe_n && bank_we_n))
      else $error("private bank active while primary owns");
    // R8
    high_space_chk: assert (!(sel_sub && seg >= 3'd3) || (rom_ce_n && com_cs_n && (&bank_cs_n)))
      else $error("select asserted above 6000");
    // R9
    one_select_chk: assert ($onehot0({~rom_ce_n, ~com_cs_n, ~bank_cs_n}))
      else $error("more than one memory selected");
    // R10
    rw_excl_chk: assert (!(!com_oe_n && !com_we_n) && !(!bank_oe_n && !bank_we_n))
      else $error("read and write enables together");
    // R10
    rw_conflict_chk: assert (!((sel_sub ? (!s_rd_n && !s_wr_n) : (!m_rd_n && !m_wr_n)))
                             || (rom_oe_n && com_oe_n && com_we_n && bank_oe_n && bank_we_n))
      else $error("conflicting strobes produced an access");
  end

endmodule

bind dual_cpu_mem_select msel_chk #(
  .ADDR_W    (ADDR_W),
  .BANK_LOG2 (BANK_LOG2),
  .N_BANKS   (N_BANKS)
) u_chk (
  .m_boot_req_n (m_boot_req_n),
  .m_ram_req_n  (m_ram_req_n),
  .m_rd_n       (m_rd_n),
  .m_wr_n       (m_wr_n),
  .s_reset_n    (s_reset_n),
  .s_grant_n    (s_grant_n),
  .s_addr_hi    (s_addr_hi),
  .s_rd_n       (s_rd_n),
  .s_wr_n       (s_wr_n),
  .sel_sub      (sel_sub),
  .rom_oe_n     (rom_oe_n),
  .rom_ce_n     (rom_ce_n),
  .rom_a12      (rom_a12),
  .com_cs_n     (com_cs_n),
  .com_oe_n     (com_oe_n),
  .com_we_n     (com_we_n),
  .bank_cs_n    (bank_cs_n),
  .bank_oe_n    (bank_oe_n),
  .bank_we_n    (bank_we_n)
);

// File: tb/sim_dual_cpu_mem_select.sv
module sim_dual_cpu_mem_select;

  logic clk;
  logic rst_n;
  logic m_boot_req_n, m_ram_req_n, m_rd_n, m_wr_n;
  logic s_reset_n, s_grant_n, s_mreq_n, s_rd_n, s_wr_n;
  logic [15:11] s_addr_hi;
  logic sel_sub, m_abuf_en_n, m_dbuf_en_n;
  logic rom_ce_n, rom_oe_n, rom_a12;
  logic com_cs_n, com_oe_n, com_we_n;
  logic [3:0] bank_cs_n;
  logic bank_oe_n, bank_we_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  dual_cpu_mem_select u0 (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (m=%b%b%b%b%b%b s=%b%b%b a=%0d)", tag, act, exp,
               m_boot_req_n, m_ram_req_n, m_rd_n, m_wr_n, s_reset_n, s_grant_n,
               s_mreq_n, s_rd_n, s_wr_n, s_addr_hi);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 40000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<40000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    {m_boot_req_n, m_ram_req_n, m_rd_n, m_wr_n} = 4'hF;
    {s_reset_n, s_grant_n, s_mreq_n, s_rd_n, s_wr_n} = 5'h1F;
    s_addr_hi = 5'd31;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // idle state: secondary owns, address in high space, nothing selected (R1, R8)
    chk("R1 idle", {5'b0, sel_sub, m_abuf_en_n, m_dbuf_en_n}, 8'h07);
    chk("R8 idle", {1'b0, rom_ce_n, com_cs_n, bank_cs_n, bank_oe_n}, 8'h7F);

    for (int m = 0; m < 64; m++) begin
      for (int sv = 0; sv < 8; sv++) begin
        for (int a = 0; a < 32; a++) begin
          int  addr, bank;
          bit  mown, mrom, mram, mrd, mwr, srd, swr, sgo;
          logic [2:0] e_rom, e_com, e_bk;
          logic [3:0] e_bcs;
          @(posedge clk);
          {m_boot_req_n, m_ram_req_n, m_rd_n, m_wr_n, s_reset_n, s_grant_n} = 6'(m);
          {s_mreq_n, s_rd_n, s_wr_n} = 3'(sv);
          s_addr_hi = 5'(a);
          addr = a * 2048;
          mrom = (m_boot_req_n == 0);
          mram = !mrom && m_ram_req_n == 0 && s_reset_n == 1 && s_grant_n == 0;
          mown = mrom || mram;
          mrd  = (m_rd_n == 0) && (m_wr_n == 1);
          mwr  = (m_wr_n == 0) && (m_rd_n == 1);
          srd  = (s_rd_n == 0) && (s_wr_n == 1);
          swr  = (s_wr_n == 0) && (s_rd_n == 1);
          sgo  = (s_mreq_n == 0);
          e_bcs = 4'hF;
          e_bk  = 3'b111;  // {cs_any_n, oe_n, we_n}
          if (mown) begin
            e_rom = {!mrom, !(mrom && mrd), 1'b1};      // {ce, oe, a12}
            e_com = {!mram, !(mram && mrd), !(mram && mwr)};
          end else begin
            bit rh, ch, bh;
            rh = addr < 'h2000;
            ch = addr >= 'h2000 && addr < 'h4000;
            bh = addr >= 'h4000 && addr < 'h6000;
            e_rom = {!rh, !(rh && sgo && srd), 1'b0};
            e_com = {!ch, !(ch && sgo && srd), !(ch && sgo && swr)};
            if (bh) begin
              bank = (addr - 'h4000) / 'h800;
              e_bcs[bank] = 1'b0;
            end
            e_bk = {!bh, !(bh && sgo && srd), !(bh && sgo && swr)};
          end
          @(negedge clk);
          chk("R1 owner", {5'b0, sel_sub, m_abuf_en_n, m_dbuf_en_n}, {5'b0, !mown, !mown, !mown});
          chk(mown ? "R2 primary rom" : "R5 secondary rom", {5'b0, rom_ce_n, rom_oe_n, rom_a12}, {5'b0, e_rom});
          chk(mown ? "R3 primary com" : "R6 secondary com", {5'b0, com_cs_n, com_oe_n, com_we_n}, {5'b0, e_com});
          chk(mown ? "R4 banks quiet" : "R7 banks", {1'b0, bank_cs_n, bank_oe_n, bank_we_n},
              {1'b0, e_bcs, e_bk[1:0]});
          if (!mown && addr >= 'h6000)
            chk("R8 high space", {2'b0, rom_ce_n, com_cs_n, bank_cs_n}, 8'h3F);
          chk("R9 single select", 8'($countones({~rom_ce_n, ~com_cs_n, ~bank_cs_n}) > 1), 8'h00);
          if ((mown && !m_rd_n && !m_wr_n) || (!mown && !s_rd_n && !s_wr_n))
            chk("R10 rd+wr ignored", {3'b0, rom_oe_n, com_oe_n, com_we_n, bank_oe_n, bank_we_n}, 8'h1F);
          chk("R10 oe/we exclusive", {6'b0, !com_oe_n && !com_we_n, !bank_oe_n && !bank_we_n}, 8'h00);
        end
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule